// File: doc/BRIEF.md
# Working-State Debug Readout Window

This block gives software a narrow register view of a bank of per-instance generator working states. Each instance contributes a 448-bit record. The record holds a 32-bit reseed counter, a 128-bit counter block V, a 256-bit key, an instantiated flag, a compliance flag, and zero padding. Software writes an index register to choose an instance. It then reads one 32-bit data register over and over, and each read steps an internal word pointer through the record, from the least significant word upward.

The pointer is a small state machine with three states:
- `S_HEAD`: the pointer is at word 0.
- `S_BODY`: the pointer is at words 1 to 12.
- `S_TAIL`: the pointer is at word 13.

Its transitions are:
- HEAD→BODY on a read.
- BODY→BODY on a read below word 12.
- BODY→TAIL on the read at word 12.
- TAIL→HEAD on a read, which wraps the pointer.
- Any state→HEAD on an accepted index write.

The window returns zero when the debug-enable input is low or when the index selects no instance. A sticky lock bit, once cleared, freezes the index register for the rest of the reset period. The state storage and the bus adapter sit outside the block; a plain write-strobe and read-strobe interface connects it.

Top module: `dbgwin_readout`

## Requirements
- R1: After reset the index is 0, the word pointer is 0 (`S_HEAD`), and `unlocked_o` is 1.
- R2: While a read strobe is high, `rdata_o` shows word `p` of the selected record, which is record bits `[32p+31:32p]`, with `p` the current pointer.
- R3: Record layout: reseed counter in bits 31:0, V in 159:32, key in 415:160, instantiated flag at 416, compliance flag at 417, and bits 447:418 zero.
- R4: The pointer advances by one on each read strobe and holds when no strobe is given.
- R5: After the read of word 13 the pointer returns to word 0.
- R6: An accepted index write sets the pointer to word 0. If a read strobe arrives in the same cycle, the index write wins.
- R7: An index of NumHwInst+1 or above (3 to 15 by default) reads as zero. Indices 0 to NumHwInst select an instance.
- R8: While `dbg_en_i` is low, `rdata_o` is zero, but read strobes still advance the pointer.
- R9: A lock write with `wdata_i[0]`=1 clears `unlocked_o`, and only reset sets it again. A lock write with bit 0 = 0 has no effect.
- R10: While `unlocked_o` is 0, index writes change neither the index nor the pointer. The index field is `wdata_i[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_en_i | input | 1 | Debug access enable |
| idx_we_i | input | 1 | Index register write strobe |
| lock_we_i | input | 1 | Lock register write strobe |
| wdata_i | input | 32 | Register write data |
| rd_stb_i | input | 1 | Data register read strobe |
| inst_cnt_i | input | 32*(NumHwInst+1) | Reseed counters, instance i at [32i+31:32i] |
| inst_v_i | input | 128*(NumHwInst+1) | V values per instance |
| inst_key_i | input | 256*(NumHwInst+1) | Keys per instance |
| inst_active_i | input | NumHwInst+1 | Instantiated flags |
| inst_fips_i | input | NumHwInst+1 | Compliance flags |
| rdata_o | output | 32 | Data register read value |
| unlocked_o | output | 1 | Index register writable |

## Verification
The bench targets the following corner cases:
- **Wrap after word 13.** An off-by-one design would return word 14 as garbage, or wrap one read early.
- **Index write in the same cycle as a read.** A design that let the read win would leave the pointer at word 1 instead of word 0.
- **Walking with debug disabled.** A design that froze the pointer would resume at the wrong word once debug returns.
- **Out-of-range indices just above the last instance.** A design with a loose bound would alias onto instance 0.
- **Index writes after the lock is cleared.** A design with a leaky lock would switch the instance or reset the pointer on such a write.

Randomised reads, peeks, index writes and enable toggles run against a bench model and cover the remaining combinations.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;
    parameter int WordW = 32;
    parameter int CntW  = 32;
    parameter int VW    = 128;
    parameter int KeyW  = 256;
    parameter int RecW  = 448;
    localparam int Words = RecW / WordW;
    localparam int PtrW  = $clog2(Words);
    localparam int PadW  = RecW - (CntW + VW + KeyW + 2);

    typedef enum logic [1:0] {
        S_HEAD = 2'd0,
        S_BODY = 2'd1,
        S_TAIL = 2'd2
    } walk_state_e;
endpackage

// File: rtl/dbgwin_cfg.sv
module dbgwin_cfg #(
    parameter int IdxW = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            idx_we_i,
    input  logic            lock_we_i,
    input  logic [IdxW-1:0] idx_wdata_i,
    input  logic            lock_wdata_i,
    output logic [IdxW-1:0] idx_o,
    output logic            idx_taken_o,
    output logic            unlocked_o
);
    logic [IdxW-1:0] idx_q;
    logic            unlocked_q;

    assign idx_taken_o = idx_we_i && unlocked_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q      <= '0;
            unlocked_q <= 1'b1;
        end else begin
            if (idx_taken_o) idx_q <= idx_wdata_i;
            if (lock_we_i && lock_wdata_i) unlocked_q <= 1'b0;
        end
    end

    assign idx_o      = idx_q;
    assign unlocked_o = unlocked_q;

    // R9: the lock never reopens without reset
    p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !unlocked_q |=> !unlocked_q);
    // R10: index frozen while locked
    p_idx_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !unlocked_q |=> $stable(idx_q));
endmodule

// File: rtl/dbgwin_walker.sv
module dbgwin_walker
    import dbgwin_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_i,
    input  logic            clr_i,
    output logic [PtrW-1:0] ptr_o
);
    walk_state_e     state_q, state_d;
    logic [PtrW-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_HEAD;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = S_HEAD;
        end else if (rd_i) begin
            unique case (state_q)
                S_HEAD:  state_d = S_BODY;
                S_BODY:  state_d = (ptr_q == PtrW'(Words - 2)) ? S_TAIL : S_BODY;
                S_TAIL:  state_d = S_HEAD;
                default: state_d = S_HEAD;
            endcase
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else if (rd_i) begin
            ptr_d = (state_q == S_TAIL) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    // R4: no strobe, no movement
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_i && !clr_i) |=> $stable(ptr_q));
    // R5: wrap after the last word
    p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !clr_i && ptr_q == PtrW'(Words - 1)) |=> (ptr_q == '0));
    // R6: accepted index write restarts the walk
    p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (ptr_q == '0 && state_q == S_HEAD));
    // R2: pointer stays inside the record
    p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_q < PtrW'(Words));
endmodule

// File: rtl/dbgwin_rec_mux.sv
module dbgwin_rec_mux
    import dbgwin_pkg::*;
#(
    parameter int NumInst = 3,
    parameter int IdxW    = 4
) (
    input  logic [NumInst*CntW-1:0] cnt_i,
    input  logic [NumInst*VW-1:0]   v_i,
    input  logic [NumInst*KeyW-1:0] key_i,
    input  logic [NumInst-1:0]      active_i,
    input  logic [NumInst-1:0]      fips_i,
    input  logic [IdxW-1:0]         idx_i,
    input  logic [PtrW-1:0]         ptr_i,
    input  logic                    dbg_en_i,
    output logic [WordW-1:0]        word_o
);
    logic [RecW-1:0] rec [NumInst];
    logic [RecW-1:0] sel_rec;

    for (genvar i = 0; i < NumInst; i++) begin : g_rec
        assign rec[i] = {{PadW{1'b0}}, fips_i[i], active_i[i],
                         key_i[i*KeyW +: KeyW], v_i[i*VW +: VW], cnt_i[i*CntW +: CntW]};
    end

    always_comb begin
        sel_rec = '0;
        for (int i = 0; i < NumInst; i++) begin
            if (idx_i == IdxW'(i)) sel_rec = rec[i];
        end
    end

    assign word_o = dbg_en_i ? sel_rec[int'(ptr_i)*WordW +: WordW] : '0;
endmodule

// File: rtl/dbgwin_readout.sv
module dbgwin_readout
    import dbgwin_pkg::*;
#(
    parameter int NumHwInst = 2,
    parameter int IdxW      = 4
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                dbg_en_i,
    input  logic                                idx_we_i,
    input  logic                                lock_we_i,
    input  logic [31:0]                         wdata_i,
    input  logic                                rd_stb_i,
    input  logic [(NumHwInst+1)*CntW-1:0]       inst_cnt_i,
    input  logic [(NumHwInst+1)*VW-1:0]         inst_v_i,
    input  logic [(NumHwInst+1)*KeyW-1:0]       inst_key_i,
    input  logic [NumHwInst:0]                  inst_active_i,
    input  logic [NumHwInst:0]                  inst_fips_i,
    output logic [31:0]                         rdata_o,
    output logic                                unlocked_o
);
    localparam int NumInst = NumHwInst + 1;

    logic [IdxW-1:0] idx;
    logic            idx_taken;
    logic [PtrW-1:0] ptr;
    logic            unused_wdata;

    assign unused_wdata = ^wdata_i[31:IdxW];

    dbgwin_cfg #(.IdxW(IdxW)) u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .idx_we_i     (idx_we_i),
        .lock_we_i    (lock_we_i),
        .idx_wdata_i  (wdata_i[IdxW-1:0]),
        .lock_wdata_i (wdata_i[0]),
        .idx_o        (idx),
        .idx_taken_o  (idx_taken),
        .unlocked_o   (unlocked_o)
    );

    dbgwin_walker u_walk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rd_i   (rd_stb_i),
        .clr_i  (idx_taken),
        .ptr_o  (ptr)
    );

    dbgwin_rec_mux #(.NumInst(NumInst), .IdxW(IdxW)) u_mux (
        .cnt_i    (inst_cnt_i),
        .v_i      (inst_v_i),
        .key_i    (inst_key_i),
        .active_i (inst_active_i),
        .fips_i   (inst_fips_i),
        .idx_i    (idx),
        .ptr_i    (ptr),
        .dbg_en_i (dbg_en_i),
        .word_o   (rdata_o)
    );

    // R8: closed window reads zero
    p_zero_dbg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dbg_en_i |-> (rdata_o == '0));
    // R7: no instance behind the index reads zero
    p_zero_oor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(idx) >= NumInst) |-> (rdata_o == '0));
    // R10: a write while locked leaves the walk where it was
    p_locked_walk_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!unlocked_o && idx_we_i && !rd_stb_i) |=> $stable(ptr));
endmodule

// File: tb/dbgwin_readout_test.sv
module dbgwin_readout_test;
    localparam int ClkPeriod = 10;
    localparam int NHw   = 2;
    localparam int NInst = NHw + 1;
    localparam int NWord = 14;

    logic clk = 0;
    logic rst_n = 0;
    logic dbg_en = 1;
    logic idx_we = 0, lock_we = 0, rd_stb = 0;
    logic [31:0] wdata = 0;
    logic [NInst*32-1:0]  cnt;
    logic [NInst*128-1:0] v;
    logic [NInst*256-1:0] key;
    logic [NInst-1:0] act, fips;
    logic [31:0] rdata;
    logic unlocked;

    int n_chk = 0, n_fail = 0;
    int idx_m = 0, ptr_m = 0;
    bit lock_m = 1;

    always #(ClkPeriod/2) clk = ~clk;

    dbgwin_readout #(.NumHwInst(NHw), .IdxW(4)) uut (
        .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(dbg_en), .idx_we_i(idx_we),
        .lock_we_i(lock_we), .wdata_i(wdata), .rd_stb_i(rd_stb),
        .inst_cnt_i(cnt), .inst_v_i(v), .inst_key_i(key),
        .inst_active_i(act), .inst_fips_i(fips),
        .rdata_o(rdata), .unlocked_o(unlocked));

    function automatic logic [31:0] exp_word(int ix, int p, bit en);
        logic [447:0] r;
        if (!en || ix >= NInst) return 32'h0;
        r = {30'b0, fips[ix], act[ix], key[ix*256 +: 256], v[ix*128 +: 128], cnt[ix*32 +: 32]};
        return r[p*32 +: 32];
    endfunction

    task automatic check(string req, logic [31:0] actv, logic [31:0] expv);
        n_chk++;
        if (actv !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (idx %0d word %0d)", req, actv, expv, idx_m, ptr_m);
        end
    endtask

    task automatic do_read(string req);
        @(negedge clk);
        rd_stb = 1;
        #1 check(req, rdata, exp_word(idx_m, ptr_m, dbg_en));
        @(posedge clk);
        #1 rd_stb = 0;
        ptr_m = (ptr_m + 1) % NWord;
    endtask

    task automatic peek(string req);
        @(negedge clk);
        #1 check(req, rdata, exp_word(idx_m, ptr_m, dbg_en));
    endtask

    task automatic wr_idx(int val, bit with_read);
        @(negedge clk);
        idx_we = 1; rd_stb = with_read; wdata = 32'(val);
        @(posedge clk);
        #1 idx_we = 0; rd_stb = 0;
        if (lock_m) begin idx_m = val & 15; ptr_m = 0; end
        else if (with_read) ptr_m = (ptr_m + 1) % NWord;
    endtask

    task automatic wr_lock(int val);
        @(negedge clk);
        lock_we = 1; wdata = 32'(val);
        @(posedge clk);
        #1 lock_we = 0;
        if (val[0]) lock_m = 0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NInst*32/32; i++) cnt[i*32 +: 32] = $urandom;
        for (int i = 0; i < NInst*4; i++) v[i*32 +: 32] = $urandom;
        for (int i = 0; i < NInst*8; i++) key[i*32 +: 32] = $urandom;
        act = 3'b101; fips = 3'b011;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        n_chk++;
        if (unlocked !== 1'b1) begin n_fail++; $display("FAIL R1: actual %b expected 1", unlocked); end
        peek("R1");

        // R2 R3 R5: full walk of every instance, plus wrap
        for (int ix = 0; ix < NInst; ix++) begin
            wr_idx(ix, 0);
            for (int w = 0; w < NWord; w++) do_read(w == 13 || w == 0 ? "R3" : "R2");
            do_read("R5");
        end
        // R3: explicit padding/flag check on word 13 of instance 0
        wr_idx(0, 0);
        repeat (13) do_read("R2");
        @(negedge clk); #1;
        check("R3", rdata, {30'b0, fips[0], act[0]});
        do_read("R3");

        // R4: idle cycles keep the word
        do_read("R4"); peek("R4"); peek("R4"); do_read("R4");

        // R6: index write restarts, and wins over a same-cycle read
        repeat (5) do_read("R6");
        wr_idx(1, 0); peek("R6");
        repeat (4) do_read("R6");
        wr_idx(2, 1); peek("R6");

        // R7: indices just past the last instance and the top
        wr_idx(3, 0); do_read("R7"); do_read("R7");
        wr_idx(15, 0); do_read("R7");

        // R8: disabled window reads zero but keeps walking
        wr_idx(1, 0);
        dbg_en = 0;
        repeat (3) do_read("R8");
        dbg_en = 1;
        peek("R8"); do_read("R8");

        // random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) do_read("R2");
            else if (op < 6) peek("R4");
            else if (op < 8) wr_idx($urandom_range(0, 15), bit'($urandom_range(0, 1)));
            else dbg_en = ~dbg_en;
        end
        dbg_en = 1;

        // R9: lock behaviour
        wr_idx(0, 0); do_read("R2"); do_read("R2");
        wr_lock(32'h2);
        n_chk++;
        if (unlocked !== 1'b1) begin n_fail++; $display("FAIL R9: actual %b expected 1", unlocked); end
        wr_lock(32'h1);
        n_chk++;
        if (unlocked !== 1'b0) begin n_fail++; $display("FAIL R9: actual %b expected 0", unlocked); end
        wr_lock(32'h0);
        n_chk++;
        if (unlocked !== 1'b0) begin n_fail++; $display("FAIL R9: actual %b expected 0", unlocked); end

        // R10: writes ignored while locked
        wr_idx(2, 0); peek("R10");
        do_read("R10");
        wr_idx(1, 1); peek("R10");
        do_read("R10");

        summary();
        $finish;
    end
endmodule